// File: doc/BRIEF.md
# Legacy Memory Region Attribute Control

This block holds the host bridge registers that govern the memory area below 1 MB, and decodes them into per-region access enables. Seven attribute bytes cover thirteen shadow regions. Each region takes a 4-bit attribute nibble. The first region is the BIOS area and uses only one nibble of the first byte. Each later pair of regions shares one byte. A separate SMRAM control byte decides two things for the 128 KB window at 0xA0000: whether normal accesses to it are sent to the PCI side, and whether the SMM-only view of it is switched on.

Software programs the registers through a byte-addressed configuration port. Each write carries a dword address and four byte enables, and a read port returns one dword. When a write lands on any attribute byte or on the SMRAM byte, every decoded output is reloaded together. All other writes leave the outputs as they are. The memory datapath that uses these enables lies outside this block.

Top module: `lmr_attr_ctrl`

## Requirements
- R1: While reset is asserted, all attribute bytes clear to 0x00 and the SMRAM byte loads 0x02. The outputs then show every region read and write enable low, `lowwin_pci` high and `smm_win_en` low.
- R2: A write stores byte lane k of `cfg_wdata` (bits 8k+7:8k) at byte address 4*`cfg_wr_dw`+k, but only when `cfg_be[k]` is set. Reading dword d returns each implemented byte in its lane, and 0 in every lane with no register behind it.
- R3: The attribute bytes sit at byte addresses 0x59 to 0x5F. Region i reads its nibble from byte 0x59+(i+1)/2 (integer division). Region 0 and every even-numbered region use bits 7:4; odd-numbered regions use bits 3:0. Bit 0 of the nibble drives `region_rd[i]` and bit 1 drives `region_wr[i]`. Bits 2 and 3 of the nibble, and bits 3:0 of byte 0x59, have no effect.
- R4: The SMRAM byte sits at address 0x72. `lowwin_pci` is high exactly when bit 6 of that byte is clear.
- R5: `smm_win_en` equals bit 3 of the SMRAM byte.
- R6: A write sampled at a rising clock edge changes all affected outputs at that same edge, together. The new values are visible in the cycle after the write and not before.
- R7: A write whose enabled bytes fall outside 0x59 to 0x5F and outside 0x72 changes neither the registers nor the outputs. This includes the unused lanes of the dwords that hold the registers.
- R8: A write with all four byte enables clear changes neither the registers nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wr_dw | input | CFG_AW-2 | Dword address of the write |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data, little-endian lanes |
| cfg_rd_dw | input | CFG_AW-2 | Dword address of the read |
| cfg_rdata | output | 32 | Read data for `cfg_rd_dw` |
| region_rd | output | NUM_REGIONS | Per-region read enable |
| region_wr | output | NUM_REGIONS | Per-region write enable |
| lowwin_pci | output | 1 | Normal accesses to the 0xA0000 window go to PCI |
| smm_win_en | output | 1 | SMM-only view of the window enabled |

## Verification
Some properties are checked on every cycle. The outputs hold whenever no write is issued or no byte enable is set. The two SMRAM outputs match bits 6 and 3 of the SMRAM byte as read back. Region 0 follows the high nibble of its byte. Reset drives the documented values. Other behaviour is shown only by the bench scenarios, run against a behavioural model: the uneven nibble packing across all thirteen regions, that writes are ignored on unused lanes and at foreign addresses, and that an output changes in exactly the cycle after its write.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
   localparam int unsigned LMR_LANES = 4;

   // byte index inside the attribute block that serves a region
   function automatic int unsigned lmr_byte_of(input int unsigned region);
      return (region + 1) / 2;
   endfunction

   // even regions (and region 0) take the upper nibble
   function automatic bit lmr_upper_nibble(input int unsigned region);
      return (region % 2) == 0;
   endfunction
endpackage

// File: rtl/lmr_cfg_regs.sv
module lmr_cfg_regs #(
   parameter int unsigned CFG_AW    = 8,
   parameter int unsigned ATTR_BASE = 'h59,
   parameter int unsigned N_ATTR    = 7,
   parameter int unsigned SMRAM_OFF = 'h72,
   parameter int unsigned SMRAM_RST = 'h02,
   localparam int unsigned DW_W     = CFG_AW - 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [DW_W-1:0]             wr_dw,
   input  logic [3:0]                  be,
   input  logic [31:0]                 wdata,
   input  logic [DW_W-1:0]             rd_dw,
   output logic [31:0]                 rdata,
   output logic [N_ATTR-1:0][7:0]      attr_nxt,
   output logic [7:0]                  smram_nxt,
   output logic                        hit
);
   localparam logic [DW_W-1:0] SM_DW   = DW_W'(SMRAM_OFF >> 2);
   localparam int unsigned     SM_LANE = SMRAM_OFF % 4;

   logic [N_ATTR-1:0][7:0] attr_q;
   logic [7:0]             smram_q;
   logic [N_ATTR-1:0]      attr_stb;
   logic                   smram_stb;

   genvar j;
   generate
      for (j = 0; j < N_ATTR; j++) begin : g_attr
         localparam logic [DW_W-1:0] BDW   = DW_W'((ATTR_BASE + j) >> 2);
         localparam int unsigned     BLANE = (ATTR_BASE + j) % 4;

         assign attr_stb[j] = wr_en && (wr_dw == BDW) && be[BLANE];
         assign attr_nxt[j] = attr_stb[j] ? wdata[BLANE*8 +: 8] : attr_q[j];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) attr_q[j] <= 8'h00;
            else        attr_q[j] <= attr_nxt[j];
         end
      end
   endgenerate

   assign smram_stb = wr_en && (wr_dw == SM_DW) && be[SM_LANE];
   assign smram_nxt = smram_stb ? wdata[SM_LANE*8 +: 8] : smram_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smram_q <= 8'(SMRAM_RST);
      else        smram_q <= smram_nxt;
   end

   assign hit = (|attr_stb) | smram_stb;

   always_comb begin
      rdata = '0;
      for (int k = 0; k < N_ATTR; k++) begin
         if (rd_dw == DW_W'((ATTR_BASE + k) >> 2))
            rdata[((ATTR_BASE + k) % 4)*8 +: 8] = attr_q[k];
      end
      if (rd_dw == SM_DW)
         rdata[SM_LANE*8 +: 8] = smram_q;
   end
endmodule

// File: rtl/lmr_region_decode.sv
module lmr_region_decode
   import lmr_pkg::*;
#(
   parameter int unsigned N_REGIONS = 13,
   localparam int unsigned N_ATTR   = (N_REGIONS + 2) / 2
) (
   input  logic [N_ATTR-1:0][7:0] attr,
   output logic [N_REGIONS-1:0]   rd_en,
   output logic [N_REGIONS-1:0]   wr_en
);
   logic unused_attr;
   assign unused_attr = ^attr;

   genvar i;
   generate
      for (i = 0; i < N_REGIONS; i++) begin : g_region
         localparam int unsigned BI = lmr_byte_of(i);
         logic [3:0] nib;
         if (lmr_upper_nibble(i)) begin : g_hi
            assign nib = attr[BI][7:4];
         end else begin : g_lo
            assign nib = attr[BI][3:0];
         end
         assign rd_en[i] = nib[0];
         assign wr_en[i] = nib[1];
      end
   endgenerate
endmodule

// File: rtl/lmr_smram_decode.sv
module lmr_smram_decode #(
   parameter int unsigned OPEN_BIT = 6,
   parameter int unsigned EN_BIT   = 3
) (
   input  logic [7:0] ctl,
   output logic       pci_route,
   output logic       smm_view
);
   logic unused_ctl;
   assign unused_ctl = ^ctl;

   assign pci_route = ~ctl[OPEN_BIT];
   assign smm_view  = ctl[EN_BIT];
endmodule

// File: rtl/lmr_attr_ctrl.sv
module lmr_attr_ctrl #(
   parameter int unsigned CFG_AW      = 8,
   parameter int unsigned NUM_REGIONS = 13,
   parameter int unsigned ATTR_BASE   = 'h59,
   parameter int unsigned SMRAM_OFF   = 'h72,
   parameter int unsigned SMRAM_RST   = 'h02,
   parameter int unsigned OPEN_BIT    = 6,
   parameter int unsigned EN_BIT      = 3,
   localparam int unsigned DW_W       = CFG_AW - 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_wr,
   input  logic [DW_W-1:0]        cfg_wr_dw,
   input  logic [3:0]             cfg_be,
   input  logic [31:0]            cfg_wdata,
   input  logic [DW_W-1:0]        cfg_rd_dw,
   output logic [31:0]            cfg_rdata,
   output logic [NUM_REGIONS-1:0] region_rd,
   output logic [NUM_REGIONS-1:0] region_wr,
   output logic                   lowwin_pci,
   output logic                   smm_win_en
);
   localparam int unsigned N_ATTR  = (NUM_REGIONS + 2) / 2;
   localparam logic        RST_PCI = 1'(((SMRAM_RST >> OPEN_BIT) & 1) == 0);
   localparam logic        RST_SMM = 1'((SMRAM_RST >> EN_BIT) & 1);

   generate
      if (CFG_AW < 3)
         $error("CFG_AW must hold at least one dword index bit");
      if (NUM_REGIONS < 1)
         $error("NUM_REGIONS must be at least 1");
      if (ATTR_BASE + N_ATTR > (1 << CFG_AW) || SMRAM_OFF >= (1 << CFG_AW))
         $error("register offsets exceed the configuration space");
      if (SMRAM_OFF >= ATTR_BASE && SMRAM_OFF < ATTR_BASE + N_ATTR)
         $error("SMRAM byte overlaps the attribute block");
      if (OPEN_BIT > 7 || EN_BIT > 7 || OPEN_BIT == EN_BIT)
         $error("SMRAM control bit positions invalid");
      if (SMRAM_RST > 255)
         $error("SMRAM reset value exceeds a byte");
   endgenerate

   logic [N_ATTR-1:0][7:0]  attr_nxt;
   logic [7:0]              smram_nxt;
   logic                    hit;
   logic [NUM_REGIONS-1:0]  dec_rd, dec_wr;
   logic                    dec_pci, dec_smm;

   lmr_cfg_regs #(
      .CFG_AW    (CFG_AW),
      .ATTR_BASE (ATTR_BASE),
      .N_ATTR    (N_ATTR),
      .SMRAM_OFF (SMRAM_OFF),
      .SMRAM_RST (SMRAM_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr),
      .wr_dw     (cfg_wr_dw),
      .be        (cfg_be),
      .wdata     (cfg_wdata),
      .rd_dw     (cfg_rd_dw),
      .rdata     (cfg_rdata),
      .attr_nxt  (attr_nxt),
      .smram_nxt (smram_nxt),
      .hit       (hit)
   );

   lmr_region_decode #(
      .N_REGIONS (NUM_REGIONS)
   ) u_region (
      .attr  (attr_nxt),
      .rd_en (dec_rd),
      .wr_en (dec_wr)
   );

   lmr_smram_decode #(
      .OPEN_BIT (OPEN_BIT),
      .EN_BIT   (EN_BIT)
   ) u_smram (
      .ctl       (smram_nxt),
      .pci_route (dec_pci),
      .smm_view  (dec_smm)
   );

   // outputs reload together, only when a write lands on a register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         region_rd  <= '0;
         region_wr  <= '0;
         lowwin_pci <= RST_PCI;
         smm_win_en <= RST_SMM;
      end else if (hit) begin
         region_rd  <= dec_rd;
         region_wr  <= dec_wr;
         lowwin_pci <= dec_pci;
         smm_win_en <= dec_smm;
      end
   end
endmodule

// File: rtl/lmr_attr_ctrl_chk.sv
module lmr_attr_ctrl_chk #(
   parameter int unsigned CFG_AW      = 8,
   parameter int unsigned NUM_REGIONS = 13,
   parameter int unsigned ATTR_BASE   = 'h59,
   parameter int unsigned SMRAM_OFF   = 'h72,
   parameter int unsigned SMRAM_RST   = 'h02,
   parameter int unsigned OPEN_BIT    = 6,
   parameter int unsigned EN_BIT      = 3,
   localparam int unsigned DW_W       = CFG_AW - 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cfg_wr,
   input logic [3:0]             cfg_be,
   input logic [DW_W-1:0]        cfg_rd_dw,
   input logic [31:0]            cfg_rdata,
   input logic [NUM_REGIONS-1:0] region_rd,
   input logic [NUM_REGIONS-1:0] region_wr,
   input logic                   lowwin_pci,
   input logic                   smm_win_en
);
   localparam logic [DW_W-1:0] SM_DW = DW_W'(SMRAM_OFF >> 2);
   localparam int unsigned     SM_B  = (SMRAM_OFF % 4) * 8;
   localparam logic [DW_W-1:0] A0_DW = DW_W'(ATTR_BASE >> 2);
   localparam int unsigned     A0_B  = (ATTR_BASE % 4) * 8;
   localparam logic RST_PCI = 1'(((SMRAM_RST >> OPEN_BIT) & 1) == 0);
   localparam logic RST_SMM = 1'((SMRAM_RST >> EN_BIT) & 1);

   logic unused_rdata;
   assign unused_rdata = ^cfg_rdata;

   AST_RESET_STATE: assert property (@(posedge clk)
      !rst_n |=> (region_rd == '0 && region_wr == '0 &&
                  lowwin_pci == RST_PCI && smm_win_en == RST_SMM)); // R1

   AST_REGION0_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_dw == A0_DW) |-> (region_rd[0] == cfg_rdata[A0_B+4] &&
                                region_wr[0] == cfg_rdata[A0_B+5])); // R3

   AST_OPEN_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_dw == SM_DW) |-> (lowwin_pci == !cfg_rdata[SM_B+OPEN_BIT])); // R4

   AST_SMM_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_dw == SM_DW) |-> (smm_win_en == cfg_rdata[SM_B+EN_BIT])); // R5

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> ($stable(region_rd) && $stable(region_wr) &&
                   $stable(lowwin_pci) && $stable(smm_win_en))); // R6

   AST_NO_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_be == 4'b0000) |=> ($stable(region_rd) && $stable(region_wr) &&
                                         $stable(lowwin_pci) && $stable(smm_win_en))); // R8
endmodule

bind lmr_attr_ctrl lmr_attr_ctrl_chk #(
   .CFG_AW      (CFG_AW),
   .NUM_REGIONS (NUM_REGIONS),
   .ATTR_BASE   (ATTR_BASE),
   .SMRAM_OFF   (SMRAM_OFF),
   .SMRAM_RST   (SMRAM_RST),
   .OPEN_BIT    (OPEN_BIT),
   .EN_BIT      (EN_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr     (cfg_wr),
   .cfg_be     (cfg_be),
   .cfg_rd_dw  (cfg_rd_dw),
   .cfg_rdata  (cfg_rdata),
   .region_rd  (region_rd),
   .region_wr  (region_wr),
   .lowwin_pci (lowwin_pci),
   .smm_win_en (smm_win_en)
);

// File: tb/sim_lmr_attr_ctrl.sv
module sim_lmr_attr_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [5:0]  cfg_wr_dw = '0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [5:0]  cfg_rd_dw = '0;
   logic [31:0] cfg_rdata;
   logic [12:0] region_rd, region_wr;
   logic        lowwin_pci, smm_win_en;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   lmr_attr_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wr_dw(cfg_wr_dw),
      .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rd_dw(cfg_rd_dw),
      .cfg_rdata(cfg_rdata), .region_rd(region_rd), .region_wr(region_wr),
      .lowwin_pci(lowwin_pci), .smm_win_en(smm_win_en)
   );

   // behavioural model: a sparse byte space
   logic [7:0] mdl [0:255];
   bit         has [0:255];

   task automatic mdl_reset();
      for (int a = 0; a < 256; a++) mdl[a] = 8'h00;
      mdl[8'h72] = 8'h02;
   endtask

   initial begin
      for (int a = 0; a < 256; a++) has[a] = (a >= 'h59 && a <= 'h5F) || a == 'h72;
      mdl_reset();
   end

   always @(posedge clk) begin
      if (!rst_n) mdl_reset();
      else if (cfg_wr) begin
         for (int k = 0; k < 4; k++) begin
            int a;
            a = cfg_wr_dw * 4 + k;
            if (cfg_be[k] && has[a]) mdl[a] = cfg_wdata[k*8 +: 8];
         end
      end
   end

   function automatic logic [3:0] nib_of(int r);
      logic [7:0] b;
      b = mdl['h59 + (r + 1) / 2];
      return (r % 2 == 1) ? b[3:0] : b[7:4];
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model (R2 R3 R4 R5 R6)
   always @(negedge clk) begin
      logic [12:0] e_rd, e_wr;
      logic [31:0] e_rdata;
      for (int r = 0; r < 13; r++) begin
         logic [3:0] n;
         n = nib_of(r);
         e_rd[r] = n[0];
         e_wr[r] = n[1];
      end
      for (int k = 0; k < 4; k++) begin
         int a;
         a = cfg_rd_dw * 4 + k;
         e_rdata[k*8 +: 8] = has[a] ? mdl[a] : 8'h00;
      end
      chk("R3 cycle region_rd", 32'(region_rd), 32'(e_rd));
      chk("R3 cycle region_wr", 32'(region_wr), 32'(e_wr));
      chk("R4 cycle lowwin_pci", 32'(lowwin_pci), 32'(!mdl['h72][6]));
      chk("R5 cycle smm_win_en", 32'(smm_win_en), 32'(mdl['h72][3]));
      chk("R2 cycle cfg_rdata", cfg_rdata, e_rdata);
   end

   task automatic wr(logic [5:0] dw, logic [3:0] be, logic [31:0] d);
      @(negedge clk); #2;
      cfg_wr = 1'b1; cfg_wr_dw = dw; cfg_be = be; cfg_wdata = d;
      @(negedge clk); #2;
      cfg_wr = 1'b0; cfg_be = '0;
   endtask

   task automatic settle();
      @(negedge clk); #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #2 rst_n = 1'b1;
      settle();
      // R1 reset state
      cfg_rd_dw = 6'h1C; settle();
      chk("R1 region_rd", 32'(region_rd), 0);
      chk("R1 region_wr", 32'(region_wr), 0);
      chk("R1 lowwin_pci", 32'(lowwin_pci), 1);
      chk("R1 smm_win_en", 32'(smm_win_en), 0);
      chk("R1 smram readback", cfg_rdata, 32'h0002_0000);

      // R3 region 0 upper nibble; lower nibble of 0x59 unused
      wr(6'h16, 4'b0010, 32'h0000_3300); settle();
      chk("R3 region0 rd", 32'(region_rd), 32'h0001);
      chk("R3 region0 wr", 32'(region_wr), 32'h0001);
      // R3 shared byte 0x5A: region1 low, region2 high
      wr(6'h16, 4'b0100, 32'h0021_0000); settle();
      chk("R3 pair rd", 32'(region_rd), 32'h0003);
      chk("R3 pair wr", 32'(region_wr), 32'h0005);
      // R3 last byte 0x5F, upper nibble bits 2/3 only
      wr(6'h17, 4'b1000, 32'hC300_0000); settle();
      chk("R3 last rd", 32'(region_rd), 32'h0803);
      chk("R3 last wr", 32'(region_wr), 32'h0805);

      // R8 no byte enables
      wr(6'h16, 4'b0000, 32'hFFFF_FFFF); settle();
      chk("R8 rd kept", 32'(region_rd), 32'h0803);
      chk("R8 wr kept", 32'(region_wr), 32'h0805);

      // R7 foreign addresses and unused lanes
      wr(6'h14, 4'b1111, 32'hFFFF_FFFF);
      wr(6'h16, 4'b0001, 32'hFFFF_FFFF);
      wr(6'h1C, 4'b1011, 32'hFFFF_FFFF);
      cfg_rd_dw = 6'h1C; settle();
      chk("R7 rd kept", 32'(region_rd), 32'h0803);
      chk("R7 wr kept", 32'(region_wr), 32'h0805);
      chk("R7 lowwin kept", 32'(lowwin_pci), 1);
      chk("R7 smm kept", 32'(smm_win_en), 0);
      chk("R7 smram byte kept", cfg_rdata, 32'h0002_0000);

      // R4 open bit
      wr(6'h1C, 4'b0100, 32'h0040_0000); settle();
      chk("R4 open clears route", 32'(lowwin_pci), 0);
      chk("R4 smm off", 32'(smm_win_en), 0);
      // R5 enable bit
      wr(6'h1C, 4'b0100, 32'h0008_0000); settle();
      chk("R5 route back", 32'(lowwin_pci), 1);
      chk("R5 smm on", 32'(smm_win_en), 1);

      // R6 timing: nothing before the edge, all after
      cfg_rd_dw = 6'h16;
      @(negedge clk); #2;
      cfg_wr = 1'b1; cfg_wr_dw = 6'h16; cfg_be = 4'b1000; cfg_wdata = 32'h1100_0000;
      #1 chk("R6 before edge", 32'(region_rd), 32'h0803);
      @(negedge clk); #1;
      chk("R6 after edge", 32'(region_rd), 32'h081B);
      #1 cfg_wr = 1'b0; cfg_be = '0;

      // R2 readback and partial lanes
      settle();
      chk("R2 readback", cfg_rdata, 32'h1121_3300);
      wr(6'h16, 4'b1110, 32'hA5B6_C7FF); settle();
      chk("R2 lane 0 empty", cfg_rdata, 32'hA5B6_C700);
      chk("R3 mixed rd", 32'(region_rd), 32'h080C);
      chk("R3 mixed wr", 32'(region_wr), 32'h0816);

      // random traffic, checked every cycle by the model
      for (int it = 0; it < 600; it++) begin
         @(negedge clk); #2;
         cfg_wr = ($urandom % 3) != 0;
         case ($urandom % 5)
            0: cfg_wr_dw = 6'h16;
            1: cfg_wr_dw = 6'h17;
            2: cfg_wr_dw = 6'h1C;
            3: cfg_wr_dw = 6'h14;
            default: cfg_wr_dw = 6'($urandom);
         endcase
         cfg_be = 4'($urandom);
         cfg_wdata = $urandom;
         case ($urandom % 3)
            0: cfg_rd_dw = 6'h16;
            1: cfg_rd_dw = 6'h17;
            default: cfg_rd_dw = 6'h1C;
         endcase
      end
      @(negedge clk); #2 cfg_wr = 1'b0;
      repeat (2) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule